// File: doc/BRIEF.md
# Slotted Audio Serial Transmitter

This block turns parallel audio samples into one serial data line while acting as bit-clock master. It accepts one sample at a time over a ready/valid input. From a bit-clock tick pulse, it produces the bit clock, a frame clock, the serial data and an output enable for an external tri-state pad. The frame clock is either a two-phase channel-select level or a short pulse at the start of the frame. The level form carries one left and one right slot. The pulse form carries up to eight time-division slots. The run-time controls set the container size, the number of active bits, the bit order, the launching clock edge, the delay of the first data bit, the slot count and the per-slot enables. A further control sets what the pad does when no data is due.

The core is one state machine that runs once per bit period. ST_IDLE holds while transfers are disabled. On the first launching edge it leaves through transition T_START. ST_LEAD counts the data offset. Transition T_OPEN enters ST_SLOT when the position in the segment equals the offset. ST_SLOT shifts out container bits and moves to the next slot through T_NEXT. After the last slot, T_CLOSE goes to ST_TAIL, which idles until the end of the segment. At a segment boundary, T_WRAP returns to ST_LEAD, or goes straight to ST_SLOT when the offset is zero. Clearing the transfer enable takes every state to ST_IDLE through T_STOP.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While `xfer_en` is 0, `bclk`, `fclk`, `sdata`, `sdata_oe`, `in_ready` and `underflow` are all 0 and the bit-clock ticks have no effect. After `xfer_en` rises, the first launching edge starts bit period 0 of a new frame.
- R2: `bclk` starts at 0 and toggles on each cycle in which `bclk_tick` is 1. With `neg_edge`=0, new bit periods begin when `bclk` rises; with `neg_edge`=1 they begin when it falls. `sdata` changes only at the start of a bit period.
- R3: When `frame_fmt` is not 1, the frame has two phases of `chan_bits`+1 bit periods each. Phase 0 is slot 0 (left) and phase 1 is slot 1 (right). `fclk` equals the phase number XOR `lrck_pol`, so with `lrck_pol`=0 the left phase is low.
- R4: When `frame_fmt` is 1, the frame has 2*(`chan_bits`+1) bit periods and `fclk` is 1 for the first `fsync_w_m1`+1 periods of each frame.
- R5: The container is 4*`size_code`+4 bits, with code 0 treated as 8. In pulse framing, `slot_cnt_m1`+1 containers follow one another. Any part of a container that would run past the end of its segment is not sent.
- R6: The first data bit of a segment appears `data_offset` bit periods after the segment start. The segment is one phase in level framing and the whole frame in pulse framing.
- R7: A slot carries `size`−`mask_bits` active bits, taken from the low end of `in_data`. The remaining `mask_bits` positions are sent as 0 after the active bits.
- R8: With `lsb_first`=0, the active bits go out most significant first. With `lsb_first`=1, they go out least significant first.
- R9: Only a slot whose bit in `slot_en` is 1 carries data. `in_ready` pulses once in the launch cycle of that slot's first bit. Disabled slots, offset periods and tail periods send 0.
- R10: `hiz_mode` 0 or 3 keeps `sdata_oe` at 1. Mode 1 makes `sdata_oe` 1 only in bit periods that carry slot data. Mode 2 behaves like mode 1, except that the first unused bit period after a data period keeps the drive for its first half.
- R11: If `in_valid` is 0 when an enabled slot starts, the slot sends zeros and `underflow` is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_tick | input | 1 | One pulse per half bit period |
| xfer_en | input | 1 | Transfer enable |
| frame_fmt | input | 3 | 1 selects pulse framing; any other code selects level framing |
| lrck_pol | input | 1 | Level framing polarity |
| size_code | input | 3 | Container size code |
| mask_bits | input | 3 | Number of trailing zero bits in each container |
| lsb_first | input | 1 | Bit order select |
| neg_edge | input | 1 | Launch on the falling edge of `bclk` |
| data_offset | input | 11 | Delay from segment start to the first data bit |
| chan_bits | input | 11 | Phase length minus one |
| slot_cnt_m1 | input | 3 | Slot count minus one (pulse framing) |
| slot_en | input | 8 | Per-slot enable mask; bit n enables slot n |
| fsync_w_m1 | input | 8 | Frame pulse width minus one |
| hiz_mode | input | 2 | Pad drive mode for unused periods |
| in_data | input | 32 | Sample input |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted in this cycle |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Serial data output enable |
| underflow | output | 1 | Sample missing at slot start |

## Verification
The bench targets these corner cases:

- **Offset truncation.** Pulse framing with eight slots and an offset that cuts the fourth container short. A design that let a slot run into the next frame would shift every later bit and misplace `fclk`.
- **Falling-edge launch.** A design that counted the first rising edge as a launch would put all data one half period early.
- **Extreme masking.** A mask of seven on an eight-bit container leaves a single active bit. An error in the mask arithmetic would send sample bits where zeros are due.
- **Half-bit tri-state.** The bench samples `sdata_oe` in both halves of each bit period, so an enable dropped at the wrong half is seen.
- **Underflow.** A run with `in_valid` held low must give zeros and one `underflow` pulse per enabled slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_CNT_W  = 11;
    localparam int DEF_SLOTS  = 8;
    localparam int DEF_FSW_W  = 8;

    localparam logic [2:0] FMT_PULSE = 3'd1;

    localparam logic [1:0] HZ_DRIVE = 2'd0;
    localparam logic [1:0] HZ_SLOT  = 2'd1;
    localparam logic [1:0] HZ_HALF  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SLOT,
        ST_TAIL
    } tx_state_t;
endpackage

// File: rtl/tdm_bclk_gen.sv
module tdm_bclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic neg_edge,
    output logic bclk,
    output logic launch,
    output logic half
);
    always_comb begin
        launch = tick && en && (bclk == neg_edge);
        half   = tick && en && (bclk != neg_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk <= 1'b0;
        end else if (!en) begin
            bclk <= 1'b0;
        end else if (tick) begin
            bclk <= ~bclk;
        end
    end

    p_bclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !bclk);
    p_bclk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && en) |=> (bclk != $past(bclk)));
endmodule

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SLOTS  = DEF_SLOTS,
    parameter int FSW_W  = DEF_FSW_W,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CONT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              launch,
    input  logic [2:0]        frame_fmt,
    input  logic              lrck_pol,
    input  logic [2:0]        size_code,
    input  logic [CNT_W-1:0]  data_offset,
    input  logic [CNT_W-1:0]  chan_bits,
    input  logic [SLOT_W-1:0] slot_cnt_m1,
    input  logic [SLOTS-1:0]  slot_en,
    input  logic [FSW_W-1:0]  fsync_w_m1,
    output logic [CONT_W-1:0] cont,
    output logic              n_used,
    output logic              n_load,
    output logic              fclk
);
    localparam int FPOS_W = CNT_W + 2;

    tx_state_t          state, n_state;
    logic [FPOS_W-1:0]  fpos, spos, n_fpos, n_spos;
    logic [CONT_W-1:0]  sbit, n_sbit;
    logic [SLOT_W-1:0]  slot_loc, n_slot, n_slot_num;
    logic [SLOT_W:0]    nslots;
    logic [FPOS_W-1:0]  phase_len, frame_len, off;
    logic               lrck_md, last_in_frame, end_seg, n_seg, slot_last, n_fclk;

    // Frame geometry derived from the run-time controls
    always_comb begin
        lrck_md       = (frame_fmt != FMT_PULSE);
        phase_len     = FPOS_W'(chan_bits) + FPOS_W'(1);
        frame_len     = phase_len << 1;
        off           = FPOS_W'(data_offset);
        cont          = (size_code == 3'd0) ? CONT_W'(8)
                        : (CONT_W'({size_code, 2'b00}) + CONT_W'(4));
        nslots        = lrck_md ? (SLOT_W+1)'(1) : ((SLOT_W+1)'(slot_cnt_m1) + (SLOT_W+1)'(1));
        last_in_frame = (fpos == frame_len - FPOS_W'(1));
        end_seg       = last_in_frame || (lrck_md && (fpos == phase_len - FPOS_W'(1)));
        slot_last     = ({1'b0, slot_loc} == nslots - (SLOT_W+1)'(1));
        n_fpos        = (state == ST_IDLE || last_in_frame) ? '0 : fpos + FPOS_W'(1);
        n_spos        = (state == ST_IDLE || end_seg) ? '0 : spos + FPOS_W'(1);
        n_seg         = lrck_md && (n_fpos >= phase_len);
    end

    // Next-state logic for the period about to start
    always_comb begin
        n_state = ST_TAIL;
        n_sbit  = '0;
        n_slot  = '0;
        if (n_spos < off) begin
            n_state = ST_LEAD;
        end else if (n_spos == off) begin
            n_state = ST_SLOT;
        end else begin
            unique case (state)
                ST_SLOT: begin
                    if (sbit == cont - CONT_W'(1)) begin
                        if (slot_last) begin
                            n_state = ST_TAIL;
                        end else begin
                            n_state = ST_SLOT;
                            n_slot  = slot_loc + SLOT_W'(1);
                        end
                    end else begin
                        n_state = ST_SLOT;
                        n_sbit  = sbit + CONT_W'(1);
                        n_slot  = slot_loc;
                    end
                end
                ST_IDLE, ST_LEAD, ST_TAIL: n_state = ST_TAIL;
                default: n_state = ST_TAIL;
            endcase
        end
    end

    // Per-period outputs handed to the data path
    always_comb begin
        n_slot_num = lrck_md ? SLOT_W'(n_seg) : n_slot;
        n_used     = (n_state == ST_SLOT) && slot_en[n_slot_num];
        n_load     = n_used && (n_sbit == '0);
        n_fclk     = lrck_md ? (n_seg ^ lrck_pol) : (n_fpos <= FPOS_W'(fsync_w_m1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fpos     <= '0;
            spos     <= '0;
            sbit     <= '0;
            slot_loc <= '0;
            fclk     <= 1'b0;
        end else if (!en) begin
            state    <= ST_IDLE;
            fpos     <= '0;
            spos     <= '0;
            sbit     <= '0;
            slot_loc <= '0;
            fclk     <= 1'b0;
        end else if (launch) begin
            state    <= n_state;
            fpos     <= n_fpos;
            spos     <= n_spos;
            sbit     <= n_sbit;
            slot_loc <= n_slot;
            fclk     <= n_fclk;
        end
    end

    p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_IDLE && !fclk));
    p_fpos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (fpos < frame_len));
    p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |-> ({1'b0, slot_loc} < nslots));
    p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLOT) |-> (sbit < cont));
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    localparam int CONT_W = $clog2(DATA_W) + 1,
    localparam int SH_W   = CONT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              launch,
    input  logic              half,
    input  logic              n_used,
    input  logic              n_load,
    input  logic [CONT_W-1:0] cont,
    input  logic [2:0]        mask_bits,
    input  logic              lsb_first,
    input  logic [1:0]        hiz_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              underflow
);
    logic [CONT_W-1:0] act;
    logic [DATA_W-1:0] lmask, raw, masked, word, shreg;
    logic              cur_used, oe_launch;

    always_comb begin
        act      = cont - CONT_W'(mask_bits);
        lmask    = (act >= CONT_W'(DATA_W)) ? '1 : ((DATA_W'(1) << act) - DATA_W'(1));
        raw      = in_valid ? in_data : '0;
        masked   = raw & lmask;
        word     = lsb_first ? masked : (masked << (SH_W'(DATA_W) - SH_W'(act)));
        in_ready = launch && n_load;
        unique case (hiz_mode)
            HZ_SLOT: oe_launch = n_used;
            HZ_HALF: oe_launch = n_used || cur_used;
            default: oe_launch = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            sdata     <= 1'b0;
            sdata_oe  <= 1'b0;
            cur_used  <= 1'b0;
            underflow <= 1'b0;
        end else if (!en) begin
            shreg     <= '0;
            sdata     <= 1'b0;
            sdata_oe  <= 1'b0;
            cur_used  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            underflow <= launch && n_load && !in_valid;
            if (launch) begin
                cur_used <= n_used;
                sdata_oe <= oe_launch;
                if (n_load) begin
                    sdata <= lsb_first ? word[0] : word[DATA_W-1];
                    shreg <= lsb_first ? (word >> 1) : (word << 1);
                end else if (n_used) begin
                    sdata <= lsb_first ? shreg[0] : shreg[DATA_W-1];
                    shreg <= lsb_first ? (shreg >> 1) : (shreg << 1);
                end else begin
                    sdata <= 1'b0;
                end
            end else if (half && hiz_mode == HZ_HALF) begin
                sdata_oe <= cur_used;
            end
        end
    end

    p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sdata && !sdata_oe && !underflow));
    p_uf_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);
    p_hiz_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && launch && hiz_mode == HZ_SLOT && !n_used) |=> !sdata_oe);
    p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && launch && !n_used) |=> !sdata);
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SLOTS  = DEF_SLOTS,
    parameter int FSW_W  = DEF_FSW_W,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int CONT_W = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_tick,
    input  logic              xfer_en,
    input  logic [2:0]        frame_fmt,
    input  logic              lrck_pol,
    input  logic [2:0]        size_code,
    input  logic [2:0]        mask_bits,
    input  logic              lsb_first,
    input  logic              neg_edge,
    input  logic [CNT_W-1:0]  data_offset,
    input  logic [CNT_W-1:0]  chan_bits,
    input  logic [SLOT_W-1:0] slot_cnt_m1,
    input  logic [SLOTS-1:0]  slot_en,
    input  logic [FSW_W-1:0]  fsync_w_m1,
    input  logic [1:0]        hiz_mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              bclk,
    output logic              fclk,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              underflow
);
    logic              launch, half, n_used, n_load;
    logic [CONT_W-1:0] cont;

    tdm_bclk_gen u_bclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (xfer_en),
        .tick     (bclk_tick),
        .neg_edge (neg_edge),
        .bclk     (bclk),
        .launch   (launch),
        .half     (half)
    );

    tdm_frame_fsm #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SLOTS  (SLOTS),
        .FSW_W  (FSW_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (xfer_en),
        .launch      (launch),
        .frame_fmt   (frame_fmt),
        .lrck_pol    (lrck_pol),
        .size_code   (size_code),
        .data_offset (data_offset),
        .chan_bits   (chan_bits),
        .slot_cnt_m1 (slot_cnt_m1),
        .slot_en     (slot_en),
        .fsync_w_m1  (fsync_w_m1),
        .cont        (cont),
        .n_used      (n_used),
        .n_load      (n_load),
        .fclk        (fclk)
    );

    tdm_tx_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (xfer_en),
        .launch    (launch),
        .half      (half),
        .n_used    (n_used),
        .n_load    (n_load),
        .cont      (cont),
        .mask_bits (mask_bits),
        .lsb_first (lsb_first),
        .hiz_mode  (hiz_mode),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .sdata     (sdata),
        .sdata_oe  (sdata_oe),
        .underflow (underflow)
    );

    p_ready_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> xfer_en);
endmodule

// File: tb/tdm_tx_serializer_tb_top.sv
module tdm_tx_serializer_tb_top;
    typedef struct packed {
        logic [2:0]  fmt;
        logic        pol;
        logic [2:0]  sz;
        logic [2:0]  msk;
        logic        lsb;
        logic        neg;
        logic [10:0] off;
        logic [10:0] chl;
        logic [2:0]  sl;
        logic [7:0]  en;
        logic [7:0]  fsw;
        logic [1:0]  hz;
    } vec_t;

    // Stimulus table: expected outputs come from the model in exp_period
    localparam vec_t VECS [7] = '{
        '{3'd0, 1'b0, 3'd3, 3'd0, 1'b0, 1'b1, 11'd1, 11'd17, 3'd0, 8'h03, 8'd0, 2'd0},
        '{3'd0, 1'b1, 3'd1, 3'd2, 1'b1, 1'b0, 11'd0, 11'd9,  3'd0, 8'h02, 8'd0, 2'd1},
        '{3'd1, 1'b0, 3'd3, 3'd4, 1'b0, 1'b0, 11'd2, 11'd39, 3'd3, 8'h0B, 8'd0, 2'd2},
        '{3'd1, 1'b0, 3'd7, 3'd0, 1'b1, 1'b1, 11'd0, 11'd31, 3'd1, 8'h01, 8'd3, 2'd2},
        '{3'd1, 1'b0, 3'd2, 3'd1, 1'b0, 1'b0, 11'd5, 11'd23, 3'd7, 8'hFF, 8'd7, 2'd2},
        '{3'd0, 1'b0, 3'd1, 3'd7, 1'b0, 1'b0, 11'd0, 11'd7,  3'd0, 8'h03, 8'd0, 2'd0},
        '{3'd5, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0, 11'd3, 11'd12, 3'd0, 8'h01, 8'd0, 2'd3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_tick = 1'b0;
    logic        xfer_en = 1'b0;
    logic [2:0]  frame_fmt = '0;
    logic        lrck_pol = 1'b0;
    logic [2:0]  size_code = '0;
    logic [2:0]  mask_bits = '0;
    logic        lsb_first = 1'b0;
    logic        neg_edge = 1'b0;
    logic [10:0] data_offset = '0;
    logic [10:0] chan_bits = '0;
    logic [2:0]  slot_cnt_m1 = '0;
    logic [7:0]  slot_en = '0;
    logic [7:0]  fsync_w_m1 = '0;
    logic [1:0]  hiz_mode = '0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready, bclk, fclk, sdata, sdata_oe, underflow;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    tdm_tx_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .xfer_en(xfer_en),
        .frame_fmt(frame_fmt), .lrck_pol(lrck_pol), .size_code(size_code),
        .mask_bits(mask_bits), .lsb_first(lsb_first), .neg_edge(neg_edge),
        .data_offset(data_offset), .chan_bits(chan_bits), .slot_cnt_m1(slot_cnt_m1),
        .slot_en(slot_en), .fsync_w_m1(fsync_w_m1), .hiz_mode(hiz_mode),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .bclk(bclk),
        .fclk(fclk), .sdata(sdata), .sdata_oe(sdata_oe), .underflow(underflow)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R1 watchdog expired act=%0d exp<=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Model of one bit period p of a frame, written from the requirements
    function automatic void exp_period(input vec_t v, input int p, output bit used,
                                       output bit fc, output int b, output int a);
        int l, seg, sp, nsl, c, d, s, sn;
        bit lr;
        l   = int'(v.chl) + 1;
        lr  = (v.fmt != 3'd1);
        seg = 0;
        sp  = p;
        nsl = 1;
        if (lr) begin
            seg = (p >= l) ? 1 : 0;
            sp  = p - seg * l;
        end else begin
            nsl = int'(v.sl) + 1;
        end
        c    = (v.sz == 3'd0) ? 8 : 4 * int'(v.sz) + 4;
        a    = c - int'(v.msk);
        used = 1'b0;
        b    = 0;
        if (sp >= int'(v.off)) begin
            d = sp - int'(v.off);
            s = d / c;
            b = d % c;
            if (s < nsl) begin
                sn   = lr ? seg : s;
                used = v.en[sn];
            end
        end
        fc = lr ? (seg[0] ^ v.pol) : (p <= int'(v.fsw));
    endfunction

    task automatic apply_cfg(input vec_t v);
        frame_fmt   = v.fmt;
        lrck_pol    = v.pol;
        size_code   = v.sz;
        mask_bits   = v.msk;
        lsb_first   = v.lsb;
        neg_edge    = v.neg;
        data_offset = v.off;
        chan_bits   = v.chl;
        slot_cnt_m1 = v.sl;
        slot_en     = v.en;
        fsync_w_m1  = v.fsw;
        hiz_mode    = v.hz;
    endtask

    // R1: everything quiet while disabled even with ticks arriving
    task automatic idle_check(input int n);
        xfer_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bclk_tick = ~bclk_tick;
            chk("R1", "idle outputs", {26'd0, bclk, fclk, sdata, sdata_oe, in_ready, underflow}, 32'd0);
        end
        bclk_tick = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int nper, input bit vmode, input string tag);
        int  k, p, b, a, flen, n_ready, n_uf, exp_loads, seq;
        bit  used, fc, prev_used, cur_used, tgl, lvl, ebit, eoe;
        logic prev_bclk;
        logic [31:0] smp;
        apply_cfg(v);
        @(negedge clk);
        flen = 2 * (int'(v.chl) + 1);
        k = -1; prev_used = 0; cur_used = 0; tgl = 0; n_ready = 0; n_uf = 0; seq = 0;
        smp = '0; prev_bclk = 1'b0; lvl = ~v.neg;
        exp_loads = 0;
        for (int j = 0; j < nper; j++) begin
            exp_period(v, j % flen, used, fc, b, a);
            if (used && b == 0) exp_loads++;
        end
        xfer_en = 1'b1;
        while (k < nper) begin
            @(negedge clk);
            if (bclk !== prev_bclk) begin
                if (bclk == lvl) begin
                    k++;
                    if (k < nper) begin
                        p = k % flen;
                        exp_period(v, p, used, fc, b, a);
                        ebit = used && (b < a) ? (v.lsb ? smp[b] : smp[a-1-b]) : 1'b0;
                        eoe  = (v.hz == 2'd1) ? used : (v.hz == 2'd2) ? (used | prev_used) : 1'b1;
                        chk(v.lsb ? "R8" : "R7", {tag, " sdata"}, {31'd0, sdata}, {31'd0, ebit});
                        chk(v.fmt == 3'd1 ? "R4" : "R3", {tag, " fclk"}, {31'd0, fclk}, {31'd0, fc});
                        chk("R10", {tag, " oe first half"}, {31'd0, sdata_oe}, {31'd0, eoe});
                        prev_used = used;
                        cur_used  = used;
                    end
                end else if (k >= 0 && k < nper) begin
                    eoe = (v.hz == 2'd1 || v.hz == 2'd2) ? cur_used : 1'b1;
                    chk("R10", {tag, " oe second half"}, {31'd0, sdata_oe}, {31'd0, eoe});
                    ebit = sdata;
                end
                prev_bclk = bclk;
            end
            if (underflow && k >= 0 && k < nper) n_uf++;
            tgl       = ~tgl;
            bclk_tick = tgl;
            in_valid  = vmode;
            in_data   = 32'h9E37_79B9 * (seq + 1) + 32'h0F0F_1234;
            #1;
            if (in_ready && (k + 1) < nper) begin
                n_ready++;
                seq++;
                smp = in_valid ? in_data : 32'd0;
            end
        end
        xfer_en   = 1'b0;
        bclk_tick = 1'b0;
        in_valid  = 1'b0;
        chk("R9", {tag, " sample loads"}, n_ready, exp_loads);
        chk("R11", {tag, " underflow pulses"}, n_uf, vmode ? 0 : exp_loads);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset state", {26'd0, bclk, fclk, sdata, sdata_oe, in_ready, underflow}, 32'd0);
        idle_check(12);
        // R2 and R5/R6 are covered through the launch-edge and slot layout of each vector
        for (int i = 0; i < 7; i++) begin
            run_vec(VECS[i], 4 * (int'(VECS[i].chl) + 1), 1'b1, $sformatf("R5 R6 R2 vec%0d", i));
        end
        // R1: stop mid-frame, stay quiet, then restart at period 0
        run_vec(VECS[0], 10, 1'b1, "R1 partial");
        idle_check(16);
        run_vec(VECS[0], 36, 1'b1, "R1 restart");
        // R11: no samples available
        run_vec(VECS[1], 40, 1'b0, "R11 starve");
        run_vec(VECS[2], 80, 1'b0, "R11 starve tdm");
        idle_check(8);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule